// File: doc/BRIEF.md
# Census Disparity Search with Left-Right Consistency

This block turns two streams of census signatures, one from the left camera and one from the right, into one disparity value for each column of a rectified scan line. Each signature is a 48-bit bit string that encodes a pixel's neighbourhood. For every column the block runs two searches over 64 shifts. The first holds the left pixel fixed and slides over the right row. The second holds the right pixel fixed and slides over the left row in the opposite direction. A candidate's similarity is the number of bit positions in which the two signatures agree. A registered pairwise-maximum tree picks the best shift in each direction.

The two winners are then compared. If they differ by less than a run-time threshold, the block outputs the left-to-right disparity. If they do not, it outputs the undefined code, which is the largest disparity plus one (64). Pixels arrive one per accepted cycle, with `in_valid` marking a real pixel. A row has a fixed length set by a parameter. The second search has to look up to 63 columns ahead, so after the last column of a row the block runs 63 internal drain steps on its own, and it emits the final results of the row during those steps.

Top module: `census_disparity`

## Requirements
- R1: The similarity of two signatures is the number of 1 bits in their bitwise XNOR, from 0 to 48. The candidate with the larger similarity wins.
- R2: The left-to-right estimate for column u pairs the left signature at u with the right signature at u−d, for d from 0 to 63.
- R3: The right-to-left estimate for column u pairs the right signature at u with the left signature at u+d, for d from 0 to 63.
- R4: A candidate column that lies before column 0 or at or beyond ROW_W (including any column of the previous row) gets a similarity of 0.
- R5: When two candidates have equal similarity, the smaller disparity wins. A row in which all signatures are equal therefore yields disparity 0 in both directions.
- R6: If |L2R − R2L| < `thresh`, then `out_disp` equals the left-to-right disparity. Otherwise it is 64, the undefined code. With `thresh` = 0 every output is 64.
- R7: Each row of ROW_W columns produces exactly ROW_W results, in column order. `out_valid` is high for one cycle per result and low at all other times.
- R8: A cycle with `in_valid` low inside a row accepts no pixel and does not change any result.
- R9: After column ROW_W−1 is accepted, the block takes 63 drain cycles. It ignores `in_valid`, `left_sig` and `right_sig` during those cycles, then starts a new row at column 0.
- R10: While `rst_n` is low and on the first cycle after it is released, `out_valid` is 0. The first accepted pixel after reset is column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | High when a left/right pixel pair is offered |
| left_sig | input | 48 | Census signature of the left pixel |
| right_sig | input | 48 | Census signature of the right pixel, same column |
| thresh | input | 7 | Consistency threshold for the difference of the two estimates |
| out_valid | output | 1 | High when `out_disp` carries a result |
| out_disp | output | 7 | Disparity 0..63, or 64 for undefined |

## Verification
A signature history that has slipped by one column shows up as a disparity off by one in a uniformly shifted scene. It does so from the first result of the row. If a tree stage lets a later candidate win a tie, an all-equal row reports a nonzero disparity instead of 0. If the delay line that aligns the two directions is misaligned, the consistency check starts failing for columns whose two estimates should agree, and the block reports undefined codes where a valid disparity is expected. A fault in the drain count changes the number of results per row, which appears by the end of the first row.

// File: rtl/census_pkg.sv
// Shared types for the census disparity search.
// Assumes: nothing beyond the 1800-2017 language.
package census_pkg;

    // Travels alongside data through the pipeline.
    // step: a history shift happened; out: this step yields a column result.
    typedef struct packed {
        logic out;
        logic step;
    } step_tag_t;

endpackage

// File: rtl/census_score.sv
// Similarity of two census signatures: the count of agreeing bit positions.
// Assumes: cand_ok low marks a candidate outside the row; it then scores 0.
module census_score #(
    parameter int SIG_W = 48,
    parameter int SCW   = $clog2(SIG_W + 1)
) (
    input  logic [SIG_W-1:0] sig_a,
    input  logic [SIG_W-1:0] sig_b,
    input  logic             cand_ok,
    output logic [SCW-1:0]   score
);
    logic [SIG_W-1:0] agree;

    // Count agreeing bits and squash candidates outside the row.
    always_comb begin
        logic [SCW-1:0] cnt;
        agree = ~(sig_a ^ sig_b);
        cnt   = '0;
        for (int i = 0; i < SIG_W; i++) cnt = cnt + SCW'(agree[i]);
        score = cand_ok ? cnt : '0;
    end
endmodule

// File: rtl/census_max_tree.sv
// Registered pairwise maximum tree over N scores that returns the winning index.
// Each level halves the candidate count. On equal scores the lower index wins.
// Assumes: N is a power of two and at least 2. Latency is $clog2(N) cycles.
module census_max_tree
    import census_pkg::*;
#(
    parameter int N   = 64,
    parameter int SCW = 6,
    parameter int IW  = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  step_tag_t      in_tag,
    input  logic [N*SCW-1:0] in_scores,
    output step_tag_t      out_tag,
    output logic [IW-1:0]  out_idx
);
    localparam int LVL = $clog2(N);

    for (genvar l = 0; l <= LVL; l++) begin : g_lvl
        localparam int W = N >> l;
        logic [SCW-1:0] sc [W];
        logic [IW-1:0]  ix [W];
        step_tag_t      tg;

        if (l == 0) begin : g_in
            for (genvar i = 0; i < W; i++) begin : g_leaf
                assign sc[i] = in_scores[i*SCW +: SCW];
                assign ix[i] = IW'(i);
            end
            assign tg = in_tag;
        end else begin : g_sel
            // One level of selectors: keep the larger score, the lower index on a tie.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tg <= '0;
                    for (int i = 0; i < W; i++) begin
                        sc[i] <= '0;
                        ix[i] <= '0;
                    end
                end else begin
                    tg <= g_lvl[l-1].tg;
                    for (int i = 0; i < W; i++) begin
                        if (g_lvl[l-1].sc[2*i+1] > g_lvl[l-1].sc[2*i]) begin
                            sc[i] <= g_lvl[l-1].sc[2*i+1];
                            ix[i] <= g_lvl[l-1].ix[2*i+1];
                        end else begin
                            sc[i] <= g_lvl[l-1].sc[2*i];
                            ix[i] <= g_lvl[l-1].ix[2*i];
                        end
                    end
                end
            end
        end
    end

    assign out_idx = g_lvl[LVL].ix[0];
    assign out_tag = g_lvl[LVL].tg;
endmodule

// File: rtl/census_disparity.sv
// Two-direction census disparity search with a consistency check.
// Holds MAX_D past signatures per side. Left-to-right compares the newest
// left pixel with older right pixels. Right-to-left compares the oldest right
// pixel with newer left pixels. Both are reduced by max trees, and the L2R
// winner is delayed MAX_D-1 steps so that both estimates refer to one column.
// Assumes: rows of exactly ROW_W pixels; after each row MAX_D-1 drain cycles
// run by themselves and ignore the inputs. MAX_D is a power of two, at least 2.
module census_disparity
    import census_pkg::*;
#(
    parameter int SIG_W = 48,
    parameter int MAX_D = 64,
    parameter int ROW_W = 640,
    localparam int DW   = $clog2(MAX_D + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SIG_W-1:0] left_sig,
    input  logic [SIG_W-1:0] right_sig,
    input  logic [DW-1:0]    thresh,
    output logic             out_valid,
    output logic [DW-1:0]    out_disp
);
    localparam int IW       = $clog2(MAX_D);
    localparam int SCW      = $clog2(SIG_W + 1);
    localparam int POS_LAST = ROW_W + MAX_D - 2;
    localparam int POS_W    = $clog2(POS_LAST + 1);

    logic [POS_W-1:0] pos;
    logic             draining, step;
    logic [SIG_W-1:0] lh [MAX_D];
    logic [SIG_W-1:0] rh [MAX_D];
    logic [MAX_D-1:0] lv, rv;
    step_tag_t        h_tag, sc_tag, l_tag, r_tag;
    logic [MAX_D*SCW-1:0] sc_l2r_c, sc_r2l_c, sc_l2r_q, sc_r2l_q;
    logic [IW-1:0]    l2r_idx, r2l_idx;
    logic [IW-1:0]    dly [MAX_D-1];
    logic             fz_go;
    logic [IW-1:0]    fz_l2r, fz_r2l, fz_diff;

    assign draining = pos >= POS_W'(ROW_W);
    assign step     = draining | in_valid;

    // Column position within the row-plus-drain sequence.
    always_ff @(posedge clk) begin
        if (!rst_n)                          pos <= '0;
        else if (step && pos == POS_W'(POS_LAST)) pos <= '0;
        else if (step)                       pos <= pos + 1'b1;
    end

    // Signature histories with in-row flags; column 0 clears older flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lv    <= '0;
            rv    <= '0;
            h_tag <= '0;
            for (int i = 0; i < MAX_D; i++) begin
                lh[i] <= '0;
                rh[i] <= '0;
            end
        end else begin
            h_tag.step <= step;
            h_tag.out  <= step && (pos >= POS_W'(MAX_D - 1));
            if (step) begin
                lh[0] <= draining ? '0 : left_sig;
                rh[0] <= draining ? '0 : right_sig;
                for (int i = 1; i < MAX_D; i++) begin
                    lh[i] <= lh[i-1];
                    rh[i] <= rh[i-1];
                end
                if (pos == '0) begin
                    lv <= MAX_D'(1);
                    rv <= MAX_D'(1);
                end else begin
                    lv <= {lv[MAX_D-2:0], !draining};
                    rv <= {rv[MAX_D-2:0], !draining};
                end
            end
        end
    end

    for (genvar d = 0; d < MAX_D; d++) begin : g_cand
        census_score #(.SIG_W(SIG_W), .SCW(SCW)) u_l2r (
            .sig_a(lh[0]), .sig_b(rh[d]), .cand_ok(rv[d]),
            .score(sc_l2r_c[d*SCW +: SCW]));
        census_score #(.SIG_W(SIG_W), .SCW(SCW)) u_r2l (
            .sig_a(rh[MAX_D-1]), .sig_b(lh[MAX_D-1-d]), .cand_ok(lv[MAX_D-1-d]),
            .score(sc_r2l_c[d*SCW +: SCW]));
    end

    // Register all candidate scores before the trees.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_l2r_q <= '0;
            sc_r2l_q <= '0;
            sc_tag   <= '0;
        end else begin
            sc_l2r_q <= sc_l2r_c;
            sc_r2l_q <= sc_r2l_c;
            sc_tag   <= h_tag;
        end
    end

    census_max_tree #(.N(MAX_D), .SCW(SCW), .IW(IW)) u_tree_l2r (
        .clk(clk), .rst_n(rst_n), .in_tag(sc_tag), .in_scores(sc_l2r_q),
        .out_tag(l_tag), .out_idx(l2r_idx));
    census_max_tree #(.N(MAX_D), .SCW(SCW), .IW(IW)) u_tree_r2l (
        .clk(clk), .rst_n(rst_n), .in_tag(sc_tag), .in_scores(sc_r2l_q),
        .out_tag(r_tag), .out_idx(r2l_idx));

    assign fz_go   = l_tag.out & r_tag.out;
    assign fz_l2r  = dly[MAX_D-2];
    assign fz_r2l  = r2l_idx;
    assign fz_diff = (fz_l2r >= fz_r2l) ? fz_l2r - fz_r2l : fz_r2l - fz_l2r;

    // Align L2R winners with the R2L winner of the same column, then fuse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_disp  <= '0;
            for (int i = 0; i < MAX_D - 1; i++) dly[i] <= '0;
        end else begin
            if (l_tag.step) begin
                dly[0] <= l2r_idx;
                for (int i = 1; i < MAX_D - 1; i++) dly[i] <= dly[i-1];
            end
            out_valid <= fz_go;
            if (fz_go)
                out_disp <= (DW'(fz_diff) < thresh) ? DW'(fz_l2r) : DW'(MAX_D);
        end
    end
endmodule

// File: rtl/census_disparity_chk.sv
// Property checker for census_disparity, attached by bind.
// Assumes: the fusion-stage signals it observes are those named in the bind.
module census_disparity_chk #(
    parameter int MAX_D = 64,
    parameter int DW    = 7,
    parameter int IW    = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] thresh,
    input logic          out_valid,
    input logic [DW-1:0] out_disp,
    input logic          fz_go,
    input logic [IW-1:0] fz_l2r,
    input logic [IW-1:0] fz_diff
);
    // R6: the result is either a real disparity or the undefined code.
    p_code_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_disp <= DW'(MAX_D));

    // R6: a zero threshold rejects every column.
    p_zero_thresh_undef_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(thresh) == '0) |-> out_disp == DW'(MAX_D));

    // R6: an accepted value is the aligned left-to-right winner.
    p_accept_is_l2r_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_disp != DW'(MAX_D)) |-> out_disp == DW'($past(fz_l2r)));

    // R6: a difference at or above the threshold forces undefined.
    p_reject_far_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && DW'($past(fz_diff)) >= $past(thresh)) |-> out_disp == DW'(MAX_D));

    // R7: a result appears only when the pipeline carried a result step.
    p_valid_from_pipe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(fz_go));

    // R10: the first cycle out of reset is quiet.
    p_quiet_after_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !out_valid);
endmodule

bind census_disparity census_disparity_chk #(.MAX_D(MAX_D), .DW(DW), .IW(IW)) u_chk (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .out_valid(out_valid),
    .out_disp(out_disp), .fz_go(fz_go), .fz_l2r(fz_l2r), .fz_diff(fz_diff));

// File: tb/census_disparity_tb.sv
`timescale 1ns/1ps
// Directed bench: each task drives one row and checks it against a bench model.
module census_disparity_tb;
    localparam int SIG_W = 48;
    localparam int MAX_D = 64;
    localparam int ROW   = 70;
    localparam int DW    = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [SIG_W-1:0] left_sig = '0, right_sig = '0;
    logic [DW-1:0] thresh = '0;
    logic out_valid;
    logic [DW-1:0] out_disp;

    always #2.5 clk = ~clk;

    census_disparity #(.SIG_W(SIG_W), .MAX_D(MAX_D), .ROW_W(ROW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .left_sig(left_sig),
        .right_sig(right_sig), .thresh(thresh), .out_valid(out_valid), .out_disp(out_disp));

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    logic [SIG_W-1:0] L [ROW];
    logic [SIG_W-1:0] R [ROW];
    int exp_d [ROW];
    int got [256];
    int got_n = 0;

    // Collect results away from the active edge.
    always @(negedge clk) if (out_valid) begin
        if (got_n < 256) got[got_n] = int'(out_disp);
        got_n++;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [SIG_W-1:0] hsig(input int s, input int x);
        logic [63:0] v;
        v = (64'(x) + 64'(s) * 64'h1_0000) * 64'h9E3779B97F4A7C15;
        v = v ^ (v >> 29);
        v = v * 64'hBF58476D1CE4E5B9;
        v = v ^ (v >> 32);
        return v[SIG_W-1:0];
    endfunction

    function automatic int sim_of(input logic [SIG_W-1:0] a, input logic [SIG_W-1:0] b);
        return $countones(~(a ^ b));
    endfunction

    // Model from R1..R6: out-of-row candidates are skipped; ties keep the smaller d.
    task automatic build_expect(input int thr);
        for (int u = 0; u < ROW; u++) begin
            int bl = -1, dl = 0, br = -1, dr = 0, df;
            for (int d = 0; d < MAX_D; d++) begin
                if (u - d >= 0 && sim_of(L[u], R[u-d]) > bl) begin bl = sim_of(L[u], R[u-d]); dl = d; end
                if (u + d < ROW && sim_of(R[u], L[u+d]) > br) begin br = sim_of(R[u], L[u+d]); dr = d; end
            end
            df = (dl > dr) ? dl - dr : dr - dl;
            exp_d[u] = (df < thr) ? dl : MAX_D;
        end
    endtask

    // Drive one row plus drain, then compare the collected results.
    task automatic run_row(input int thr, input bit gaps, input bit junk, input string req);
        thresh = DW'(thr);
        build_expect(thr);
        got_n = 0;
        for (int c = 0; c < ROW; c++) begin
            if (gaps && (c % 3 == 1)) begin
                @(negedge clk);
                in_valid = 1'b0;
                left_sig = hsig(99, c);
                right_sig = hsig(98, c);
            end
            @(negedge clk);
            in_valid = 1'b1;
            left_sig = L[c];
            right_sig = R[c];
        end
        for (int k = 0; k < MAX_D - 1; k++) begin
            @(negedge clk);
            in_valid = junk;
            left_sig = hsig(77, k);
            right_sig = hsig(78, k);
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (14) @(negedge clk);
        check(got_n == ROW, "R7 result count", got_n, ROW);
        for (int u = 0; u < ROW && u < got_n; u++)
            check(got[u] == exp_d[u], req, got[u], exp_d[u]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R10 in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 after release", int'(out_valid), 0);
    endtask

    task automatic t_shift(input int k);
        for (int x = 0; x < ROW; x++) begin
            L[x] = hsig(1, x);
            R[x] = hsig(1, x + k);
        end
        run_row(127, 0, 0, "R1 R2 R3 shifted scene");
        check(got[ROW/2] == k, "R2 mid-row disparity", got[ROW/2], k);
        check(got[k] == k, "R4 edge column", got[k], k);
    endtask

    task automatic t_ties();
        for (int x = 0; x < ROW; x++) begin
            L[x] = 48'h5A5A_0F0F_3C3C;
            R[x] = 48'h5A5A_0F0F_3C3C;
        end
        run_row(1, 0, 0, "R5 tie picks smaller d");
        check(got[ROW-1] == 0, "R5 last column", got[ROW-1], 0);
    endtask

    task automatic t_random(input int thr, input string req);
        for (int x = 0; x < ROW; x++) begin
            L[x] = hsig(5, x);
            R[x] = hsig(5, x + 3) ^ (48'h1 << (x % 48));
        end
        run_row(thr, 0, 0, req);
    endtask

    task automatic t_gaps();
        for (int x = 0; x < ROW; x++) begin
            L[x] = hsig(7, x);
            R[x] = hsig(7, x + 9);
        end
        run_row(3, 1, 0, "R8 stalls inside row");
    endtask

    task automatic t_junk_drain();
        for (int x = 0; x < ROW; x++) begin
            L[x] = hsig(11, x);
            R[x] = hsig(11, x + 30);
        end
        run_row(2, 0, 1, "R9 drain ignores inputs");
        for (int x = 0; x < ROW; x++) begin
            L[x] = hsig(12, x);
            R[x] = hsig(12, x + 1);
        end
        run_row(127, 0, 0, "R4 R9 next row starts clean");
    endtask

    initial begin
        t_reset();
        t_shift(5);
        t_shift(20);
        t_ties();
        t_random(0, "R6 zero threshold");
        t_random(3, "R6 threshold 3");
        t_random(4, "R6 threshold 4");
        t_gaps();
        t_junk_drain();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule